// File: doc/BRIEF.md
# SDRAM Mode Register and Column Burst Sequencer

This block is the device-side model of an SDRAM mode register together with the column burst logic that the register steers. A load command takes a 12-bit mode word from the address bus. The stored word sets the burst length, the burst ordering, the read latency, the operating mode and whether writes burst or touch one location. Each later read or write command carries a starting column. The block then emits one column address per cycle for the burst and, for reads, raises a data-valid strobe once the programmed latency has passed.

The block also polices how it is programmed. A load is refused while any bank is open, or while a burst or read-data tail is still in flight. After a legal load, a fixed number of cycles must pass before the next command is accepted. A word that holds any reserved code leaves a sticky error flag set, and reads and writes are then refused. Non-zero upper address bits or bank bits in a load word raise a warning.

Two state machines run the block. The control machine has the states CTL_READY and CTL_MRD_WAIT. A legal load moves it from CTL_READY to CTL_MRD_WAIT, and the wait counter reaching its last cycle moves it back to CTL_READY. The burst machine has the states BG_IDLE and BG_RUN. An accepted read or write moves it from BG_IDLE to BG_RUN. It returns to BG_IDLE either after the final beat or when the stop input is sampled.

Top module: `sdram_mode_burst`

## Requirements
- R1: After reset, mode_err is 1, col_valid, rd_valid, load_err, wait_err, cmd_refused and mode_warn are 0, and a read command is refused.
- R2: cmd_op encodes 0 as no-op, 1 as load, 2 as read and 3 as write. A legal load stores cmd_addr as the mode word. Bits 2..0 give the length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit 3 gives the ordering: 0=sequential, 1=interleaved. Bits 6..4 give the read latency: 010=2, 011=3. A word with no reserved code clears mode_err.
- R3: A legal load of a word with a reserved code sets mode_err. The reserved codes are: length 100, 101 or 110; length 111 with bit 3 = 1; latency other than 010 or 011; bits 8..7 not 00. While mode_err is set, every read or write gives a one-cycle cmd_refused pulse and no col_valid.
- R4: A load sampled while banks_idle is 0, or while a burst or read-valid tail is pending, gives a one-cycle load_err pulse on the following cycle, and the stored mode stays unchanged.
- R5: For MODE_WAIT edges after a legal load, any command other than a no-op gives a one-cycle wait_err pulse and is ignored. The next command after that window is accepted.
- R6: A legal load with cmd_addr[11:10] or cmd_bank non-zero sets mode_warn. mode_warn holds until the next legal load, which recomputes it.
- R7: For a burst accepted at edge n, beat t (t = 0..L-1) is shown with col_valid high in the cycle after edge n+t. In sequential mode with length L of 1, 2, 4 or 8, the beat's column is (start & ~(L-1)) | ((start+t) & (L-1)).
- R8: In interleaved mode, the column of beat t is start XOR t.
- R9: A full-page burst runs for 2^COL_W beats with column (start+t) mod 2^COL_W. If burst_stop is sampled high during a burst, no beat is shown after that edge.
- R10: With bit 9 of the mode word set, a write burst has exactly one beat, while reads keep the programmed length.
- R11: For a read accepted at edge n with latency CL, rd_valid is high in the cycles after edges n+CL through n+CL+L-1 and low otherwise. col_write is 0 for reads and 1 for writes.
- R12: A read or write sampled while a burst is running gives a one-cycle cmd_refused pulse and does not disturb the running burst. At most one of load_err, wait_err and cmd_refused is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 0 no-op, 1 load, 2 read, 3 write |
| cmd_addr | input | 12 | Mode word for a load, start column in the low COL_W bits for read or write |
| cmd_bank | input | BA_W | Bank bits; must be zero for a load |
| banks_idle | input | 1 | All banks are precharged |
| burst_stop | input | 1 | Ends the running burst after the current beat |
| col_valid | output | 1 | A burst beat is present |
| col_addr | output | COL_W | Column of the current beat |
| col_write | output | 1 | Current burst is a write |
| rd_valid | output | 1 | Read data is valid this cycle |
| mode_err | output | 1 | Sticky: no valid mode word is stored |
| mode_warn | output | 1 | Last legal load had non-zero reserved bits |
| load_err | output | 1 | Pulse: load refused because the device was not idle |
| wait_err | output | 1 | Pulse: command issued during the post-load wait |
| cmd_refused | output | 1 | Pulse: read or write refused (bad mode or busy) |

## Verification
The main sweep programs every combination of the four short lengths, both orderings and both latencies, and starts a read at each of the first sixteen columns. Those starts cross every aligned block boundary. The sweep separates wrap-within-block from a plain increment, and XOR ordering from either of them. Counting rd_valid cycles per read tells latency 2 from latency 3 and catches an off-by-one strobe. Further patterns cover full-page bursts that cross the page end, bursts cut short by the stop input, single-beat writes next to full-length reads, loads during a burst or with banks open, commands in the wait window, and each reserved code.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

    localparam int MODE_W = 12;
    localparam int CL_MAX = 3;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } cmd_op_e;

    typedef enum logic {
        CTL_READY    = 1'b0,
        CTL_MRD_WAIT = 1'b1
    } ctl_state_e;

    typedef enum logic {
        BG_IDLE = 1'b0,
        BG_RUN  = 1'b1
    } bg_state_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic       lat3;
        logic       wr_single;
    } mode_cfg_t;

endpackage

// File: rtl/sdram_mode_decode.sv
module sdram_mode_decode
    import sdram_mode_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic [MODE_W-1:0] word,
    input  logic [BA_W-1:0]   bank,
    output mode_cfg_t         cfg,
    output logic              reserved,
    output logic              warn
);

    logic len_bad;
    logic lat_bad;
    logic opm_bad;

    always_comb begin
        cfg.len_code   = word[2:0];
        cfg.interleave = word[3];
        cfg.lat3       = word[4];
        cfg.wr_single  = word[9];

        unique case (word[2:0])
            3'b000, 3'b001, 3'b010, 3'b011: len_bad = 1'b0;
            3'b111:                         len_bad = word[3];
            default:                        len_bad = 1'b1;
        endcase

        lat_bad  = !((word[6:4] == 3'b010) || (word[6:4] == 3'b011));
        opm_bad  = (word[8:7] != 2'b00);
        reserved = len_bad || lat_bad || opm_bad;
        warn     = (word[11:10] != 2'b00) || (bank != '0);
    end

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
    import sdram_mode_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             interleave,
    input  logic             single,
    input  logic             stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             busy
);

    bg_state_e        state_q, state_d;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             inter_q;
    logic             take;
    logic             last_beat;

    function automatic logic [COL_W-1:0] mask_of(input logic [2:0] code);
        unique case (code)
            3'b000:  return '0;
            3'b001:  return COL_W'(1);
            3'b010:  return COL_W'(3);
            3'b011:  return COL_W'(7);
            3'b111:  return '1;
            default: return '0;
        endcase
    endfunction

    assign take      = start && (state_q == BG_IDLE);
    assign last_beat = (beat_q == mask_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BG_IDLE: if (take) state_d = BG_RUN;
            BG_RUN:  if (stop || last_beat) state_d = BG_IDLE;
            default: state_d = BG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q  <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            inter_q <= 1'b0;
        end else if (take) begin
            beat_q  <= '0;
            base_q  <= start_col;
            mask_q  <= single ? '0 : mask_of(len_code);
            inter_q <= interleave;
        end else if (state_q == BG_RUN) begin
            beat_q  <= beat_q + COL_W'(1);
        end
    end

    always_comb begin
        col_valid = (state_q == BG_RUN);
        busy      = (state_q == BG_RUN);
        if (inter_q) col_addr = base_q ^ beat_q;
        else         col_addr = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
    end

    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BG_RUN) |-> (beat_q <= mask_q)); // R7

    AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (col_valid && (col_addr == $past(start_col)))); // R8

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BG_RUN) |-> !start); // R12

endmodule

// File: rtl/sdram_rd_latency.sv
module sdram_rd_latency
    import sdram_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_rd,
    input  logic lat3,
    output logic rd_valid,
    output logic pipe_busy
);

    logic [CL_MAX-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[CL_MAX-2:0], beat_rd};
    end

    assign rd_valid  = lat3 ? sr_q[CL_MAX-1] : sr_q[CL_MAX-2];
    assign pipe_busy = |sr_q;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (lat3 ? $past(beat_rd, 3) : $past(beat_rd, 2))); // R11

endmodule

// File: rtl/sdram_mode_burst.sv
module sdram_mode_burst
    import sdram_mode_pkg::*;
#(
    parameter int COL_W     = 8,
    parameter int BA_W      = 2,
    parameter int MODE_WAIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_op,
    input  logic [MODE_W-1:0] cmd_addr,
    input  logic [BA_W-1:0]   cmd_bank,
    input  logic              banks_idle,
    input  logic              burst_stop,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_write,
    output logic              rd_valid,
    output logic              mode_err,
    output logic              mode_warn,
    output logic              load_err,
    output logic              wait_err,
    output logic              cmd_refused
);

    localparam int WAIT_W = $clog2(MODE_WAIT + 1);

    ctl_state_e        state_q, state_d;
    logic [WAIT_W-1:0] wait_cnt_q;
    logic [MODE_W-1:0] mode_word_q;
    cmd_op_e           op;
    mode_cfg_t         new_cfg, cur_cfg;
    logic              new_res, new_warn, cur_res, cur_warn;
    logic              bg_busy, pipe_busy, all_idle, is_rw, in_ready;
    logic              do_load, rej_load, burst_start, refuse, wait_hit;
    logic              single_beat;
    logic              unused_dec;

    assign op = cmd_op_e'(cmd_op);

    sdram_mode_decode #(.BA_W(BA_W)) dec_new_i (
        .word     (cmd_addr),
        .bank     (cmd_bank),
        .cfg      (new_cfg),
        .reserved (new_res),
        .warn     (new_warn)
    );

    sdram_mode_decode #(.BA_W(BA_W)) dec_cur_i (
        .word     (mode_word_q),
        .bank     ('0),
        .cfg      (cur_cfg),
        .reserved (cur_res),
        .warn     (cur_warn)
    );

    assign unused_dec = &{1'b0, new_cfg, cur_res, cur_warn};

    always_comb begin
        in_ready    = (state_q == CTL_READY);
        is_rw       = (op == OP_READ) || (op == OP_WRITE);
        all_idle    = banks_idle && !bg_busy && !pipe_busy;
        do_load     = in_ready && (op == OP_LOAD) && all_idle;
        rej_load    = in_ready && (op == OP_LOAD) && !all_idle;
        burst_start = in_ready && is_rw && !mode_err && !bg_busy;
        refuse      = in_ready && is_rw && (mode_err || bg_busy);
        wait_hit    = (state_q == CTL_MRD_WAIT) && (op != OP_NOP);
        single_beat = (op == OP_WRITE) && cur_cfg.wr_single;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_READY:    if (do_load) state_d = CTL_MRD_WAIT;
            CTL_MRD_WAIT: if (wait_cnt_q == WAIT_W'(1)) state_d = CTL_READY;
            default:      state_d = CTL_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTL_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt_q  <= '0;
            mode_word_q <= '0;
            mode_err    <= 1'b1;
            mode_warn   <= 1'b0;
            load_err    <= 1'b0;
            wait_err    <= 1'b0;
            cmd_refused <= 1'b0;
            col_write   <= 1'b0;
        end else begin
            load_err    <= rej_load;
            wait_err    <= wait_hit;
            cmd_refused <= refuse;
            if (do_load) begin
                wait_cnt_q  <= WAIT_W'(MODE_WAIT);
                mode_word_q <= cmd_addr;
                mode_err    <= new_res;
                mode_warn   <= new_warn;
            end else if (state_q == CTL_MRD_WAIT) begin
                wait_cnt_q  <= wait_cnt_q - WAIT_W'(1);
            end
            if (burst_start) col_write <= (op == OP_WRITE);
        end
    end

    sdram_burst_gen #(.COL_W(COL_W)) burst_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (burst_start),
        .start_col  (cmd_addr[COL_W-1:0]),
        .len_code   (cur_cfg.len_code),
        .interleave (cur_cfg.interleave),
        .single     (single_beat),
        .stop       (burst_stop),
        .col_valid  (col_valid),
        .col_addr   (col_addr),
        .busy       (bg_busy)
    );

    sdram_rd_latency lat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_rd   (col_valid && !col_write),
        .lat3      (cur_cfg.lat3),
        .rd_valid  (rd_valid),
        .pipe_busy (pipe_busy)
    );

    AST_LOAD_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> $stable(mode_word_q)); // R4

    AST_WAIT_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_MRD_WAIT) |-> (!col_valid && !burst_start)); // R5

    AST_BAD_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_err && !col_valid && (state_q == CTL_READY)) |=> !col_valid); // R3

    AST_ONE_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_err, wait_err, cmd_refused})); // R12

endmodule

// File: tb/sdram_mode_burst_tb_top.sv
module sdram_mode_burst_tb_top;

    localparam int COL_W = 8;
    localparam int MODE_WAIT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [11:0] cmd_addr = '0;
    logic [1:0]  cmd_bank = '0;
    logic        banks_idle = 1'b1;
    logic        burst_stop = 1'b0;
    logic        col_valid, col_write, rd_valid, mode_err, mode_warn;
    logic        load_err, wait_err, cmd_refused;
    logic [COL_W-1:0] col_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_mode_burst #(.COL_W(COL_W), .BA_W(2), .MODE_WAIT(MODE_WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_bank(cmd_bank), .banks_idle(banks_idle), .burst_stop(burst_stop),
        .col_valid(col_valid), .col_addr(col_addr), .col_write(col_write),
        .rd_valid(rd_valid), .mode_err(mode_err), .mode_warn(mode_warn),
        .load_err(load_err), .wait_err(wait_err), .cmd_refused(cmd_refused)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [11:0] a, input logic [1:0] b);
        cmd_op = op; cmd_addr = a; cmd_bank = b;
        step();
        cmd_op = 2'd0; cmd_addr = '0; cmd_bank = '0;
    endtask

    function automatic logic [11:0] mk(input int lc, input int ty, input int cl, input int ws);
        return 12'((ws << 9) | (cl << 4) | (ty << 3) | lc);
    endfunction

    task automatic load(input logic [11:0] w, input logic [1:0] b);
        issue(2'd1, w, b);
        repeat (MODE_WAIT) step();
    endtask

    function automatic int expc(input int s, input int t, input int len, input bit inter);
        if (inter) return (s ^ t) & 255;
        return ((s & ~(len - 1)) | ((s + t) & (len - 1))) & 255;
    endfunction

    task automatic run_burst(input logic [1:0] op, input int s, input int len, input bit inter,
                             input int cl, input int stop_at, input string req);
        int leff;
        int bad;
        int bad_t;
        int act;
        int exp;
        leff = (stop_at > 0) ? stop_at : len;
        bad = 0; bad_t = -1; act = 0; exp = 0;
        issue(op, 12'(s), 2'd0);
        for (int t = 0; t < leff + cl + 2; t++) begin
            bit ecv;
            bit erd;
            ecv = (t < leff);
            erd = (op == 2'd2) && (t >= cl) && (t < cl + leff);
            if (col_valid !== ecv || rd_valid !== erd ||
                (ecv && (int'(col_addr) != expc(s, t, len, inter))) ||
                (ecv && (col_write !== (op == 2'd3)))) begin
                if (bad == 0) begin
                    bad_t = t;
                    act = {col_valid, rd_valid, col_write, col_addr};
                    exp = {ecv, erd, (op == 2'd3), 8'(ecv ? expc(s, t, len, inter) : int'(col_addr))};
                end
                bad++;
            end
            burst_stop = (stop_at > 0) && (t == stop_at - 1);
            step();
        end
        burst_stop = 1'b0;
        check(bad == 0, req, $sformatf("burst start=%0d len=%0d cl=%0d first bad beat %0d (valid,rd,wr,col)",
              s, len, cl, bad_t), act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(mode_err == 1'b1, "R1", "mode_err after reset", mode_err, 1);
        check({col_valid, rd_valid, load_err, wait_err, cmd_refused, mode_warn} == 6'b0,
              "R1", "outputs after reset",
              {col_valid, rd_valid, load_err, wait_err, cmd_refused, mode_warn}, 0);
        issue(2'd2, 12'd4, 2'd0);
        check(cmd_refused && !col_valid, "R1", "read refused before load",
              {cmd_refused, col_valid}, 2);
        step();

        // R3 reserved encodings
        begin
            logic [11:0] bad_words [5];
            bad_words[0] = 12'h024; bad_words[1] = 12'h02F; bad_words[2] = 12'h012;
            bad_words[3] = 12'h042; bad_words[4] = 12'h0A2;
            foreach (bad_words[i]) begin
                load(12'h022, 2'd0);
                check(!mode_err, "R2", "valid word clears mode_err", mode_err, 0);
                load(bad_words[i], 2'd0);
                check(mode_err, "R3", $sformatf("reserved word %h", bad_words[i]), mode_err, 1);
                issue(2'd3, 12'd1, 2'd0);
                check(cmd_refused && !col_valid, "R3", "write refused under bad mode",
                      {cmd_refused, col_valid}, 2);
                step();
                check(!col_valid, "R3", "no beat under bad mode", col_valid, 0);
            end
        end

        // R7 R8 R11 sweep of short bursts
        for (int lc = 0; lc < 4; lc++)
            for (int ty = 0; ty < 2; ty++)
                for (int cl = 2; cl < 4; cl++) begin
                    load(mk(lc, ty, cl, 0), 2'd0);
                    check(!mode_err, "R2", "valid sweep word", mode_err, 0);
                    for (int s = 0; s < 16; s++)
                        run_burst(2'd2, s, 1 << lc, ty[0], cl, 0, ty ? "R8 R11" : "R7 R11");
                    run_burst(2'd3, 13, 1 << lc, ty[0], cl, 0, "R11 write");
                end

        // R9 full page
        load(mk(7, 0, 3, 0), 2'd0);
        check(!mode_err, "R2", "full page sequential is legal", mode_err, 0);
        run_burst(2'd2, 250, 256, 1'b0, 3, 0, "R9");
        run_burst(2'd3, 0, 256, 1'b0, 3, 0, "R9");
        run_burst(2'd2, 3, 256, 1'b0, 3, 10, "R9 stop");
        load(mk(3, 1, 2, 0), 2'd0);
        run_burst(2'd2, 5, 8, 1'b1, 2, 3, "R9 stop short");

        // R10 single write
        load(mk(3, 0, 2, 1), 2'd0);
        run_burst(2'd3, 5, 1, 1'b0, 2, 0, "R10");
        run_burst(2'd2, 5, 8, 1'b0, 2, 0, "R10");

        // R4 refused loads
        load(mk(3, 0, 2, 0), 2'd0);
        banks_idle = 1'b0;
        issue(2'd1, mk(1, 1, 3, 0), 2'd0);
        check(load_err, "R4", "load with banks open", load_err, 1);
        banks_idle = 1'b1;
        step();
        check(!load_err, "R4", "load_err is a pulse", load_err, 0);
        run_burst(2'd2, 3, 8, 1'b0, 2, 0, "R4 mode kept");
        issue(2'd2, 12'd0, 2'd0);
        issue(2'd1, mk(1, 1, 3, 0), 2'd0);
        check(load_err && col_valid, "R4", "load during burst", {load_err, col_valid}, 3);
        repeat (14) step();
        run_burst(2'd2, 6, 8, 1'b0, 2, 0, "R4 mode kept after burst");

        // R12 busy refusal
        issue(2'd2, 12'd8, 2'd0);
        issue(2'd3, 12'd40, 2'd0);
        check(cmd_refused && col_valid && col_addr == 8'd9 && !col_write, "R12",
              "command during burst refused", {cmd_refused, col_valid, col_addr}, {2'b11, 8'd9});
        repeat (14) step();

        // R5 wait window
        issue(2'd1, mk(2, 0, 2, 0), 2'd0);
        issue(2'd2, 12'd1, 2'd0);
        check(wait_err && !col_valid, "R5", "read in wait slot 1", {wait_err, col_valid}, 2);
        issue(2'd1, mk(0, 0, 3, 0), 2'd0);
        check(wait_err && !col_valid, "R5", "load in wait slot 2", {wait_err, col_valid}, 2);
        run_burst(2'd2, 1, 4, 1'b0, 2, 0, "R5 accepted after wait");

        // R6 warnings
        load(12'h422, 2'd0);
        check(mode_warn && !mode_err, "R6", "bit 10 set", {mode_warn, mode_err}, 2);
        load(12'h022, 2'd0);
        check(!mode_warn, "R6", "clean load clears", mode_warn, 0);
        load(12'h022, 2'd1);
        check(mode_warn, "R6", "bank bits set", mode_warn, 1);
        banks_idle = 1'b0;
        issue(2'd1, 12'h022, 2'd0);
        banks_idle = 1'b1;
        check(mode_warn, "R6", "refused load keeps warn", mode_warn, 1);
        load(12'h822, 2'd0);
        check(mode_warn, "R6", "bit 11 set", mode_warn, 1);
        load(12'h022, 2'd0);
        check(!mode_warn, "R6", "clean load clears again", mode_warn, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule